// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard logic of a five-stage in-order pipeline. The stages, in order, are fetch, decode, execute, memory and write-back. On each cycle it looks at register numbers and control flags held in the inter-stage registers, and it decides three things. First, where each execute-stage ALU operand should come from. Second, whether the front of the pipeline must freeze because of a load-use dependency. Third, whether a wrongly fetched instruction must be discarded after a taken branch.

The unit is purely combinational. The surrounding datapath feeds it the source and destination register numbers, the register-write flags and the memory-read flag. It also feeds it the branch outcome, which is resolved in decode. The datapath then applies the unit's outputs at the next clock edge. Branches are predicted not taken, so the instruction after a branch is fetched at once and then dropped if the branch is taken. A register-address width parameter sizes the unit. A second parameter chooses whether register 0 is treated as a constant zero that is never forwarded.

Top module: `hz_unit`

## Requirements
- R1: When the EX/MEM stage writes a register (write flag set, destination nonzero) that equals operand A's source in ID/EX, `fwd_sel_a` is 2'b10.
- R2: When only the MEM/WB stage writes a matching nonzero register for operand A, `fwd_sel_a` is 2'b01.
- R3: When both EX/MEM and MEM/WB match the same operand source, the EX/MEM code 2'b10 is chosen.
- R4: A stage whose register-write flag is clear is never a forwarding source, whatever its destination number.
- R5: A destination of register 0 is never forwarded; the select stays 2'b00, which means the register-file value.
- R6: Operand B (`fwd_sel_b`, source `idex_src2`) follows the same rules as operand A, independently of it.
- R7: When the ID/EX entry has its memory-read flag set and its destination equals either IF/ID source register, `pc_ifid_hold` is 1.
- R8: No hold is raised when the ID/EX entry is not a memory read, or when its destination matches neither IF/ID source.
- R9: `idex_bubble` is 1 in exactly the cycles in which the load-use hold is raised.
- R10: When `id_br_taken` is 1 and no hold is raised, `ifid_flush` is 1; with `id_br_taken` at 0 it is 0.
- R11: When a hold and a taken branch occur together, the hold wins: `ifid_flush` is 0 and `pc_ifid_hold` is 1.
- R12: The select code 2'b11 is never produced, and with every input at zero all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_src1 | input | AW | First source register of the instruction in decode |
| ifid_src2 | input | AW | Second source register of the instruction in decode |
| idex_src1 | input | AW | Operand A source register in the ID/EX entry |
| idex_src2 | input | AW | Operand B source register in the ID/EX entry |
| idex_dst | input | AW | Destination register of the ID/EX entry |
| idex_mem_rd | input | 1 | ID/EX entry is a memory load |
| exmem_dst | input | AW | Destination register of the EX/MEM entry |
| exmem_reg_wr | input | 1 | EX/MEM entry writes a register |
| memwb_dst | input | AW | Destination register of the MEM/WB entry |
| memwb_reg_wr | input | 1 | MEM/WB entry writes a register |
| id_br_taken | input | 1 | Branch resolved in decode is taken |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| pc_ifid_hold | output | 1 | Freeze the PC and the IF/ID register |
| idex_bubble | output | 1 | Zero the control bits entering ID/EX |
| ifid_flush | output | 1 | Discard the instruction in IF/ID |

## Verification
The bench targets several corner cases, each tied to a specific fault:
- Both later stages writing the register an operand needs: a design with the wrong priority would feed the older MEM/WB value to the ALU.
- A matching destination of register 0, or a matching destination whose write flag is clear: an unguarded comparator would forward stale or meaningless data.
- A load whose destination matches only the second decode source, and a non-load producer that does match: a detector that checks one source only, or ignores the read flag, would miss a stall or add needless ones.
- A taken branch during a load-use stall: a design without the precedence rule would discard the instruction that the stall is holding.

Random stimulus over a narrow range of register numbers makes matches frequent, and a bench model checks every output of every vector.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_sel_e;

   localparam int NUM_OPERANDS = 2;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
   import hz_pkg::*;
#(
   parameter int AW = 5,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] mem_dst,
   input  logic          mem_wr,
   input  logic [AW-1:0] wb_dst,
   input  logic          wb_wr,
   output fwd_sel_e      sel
);
   logic mem_live;
   logic wb_live;

   generate
      if (ZERO_REG_HARDWIRED) begin : g_zero_skip
         assign mem_live = mem_wr && (mem_dst != '0);
         assign wb_live  = wb_wr  && (wb_dst  != '0);
      end else begin : g_no_skip
         assign mem_live = mem_wr;
         assign wb_live  = wb_wr;
      end
   endgenerate

   always_comb begin
      if (mem_live && (mem_dst == src)) begin
         sel = FWD_MEM;
      end else if (wb_live && (wb_dst == src)) begin
         sel = FWD_WB;
      end else begin
         sel = FWD_RF;
      end
   end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] id_src1,
   input  logic [AW-1:0] id_src2,
   input  logic [AW-1:0] ex_dst,
   input  logic          ex_mem_rd,
   output logic          hit
);
   logic match1;
   logic match2;

   assign match1 = (ex_dst == id_src1);
   assign match2 = (ex_dst == id_src2);
   assign hit    = ex_mem_rd && (match1 || match2);
endmodule

// File: rtl/hz_flow_ctrl.sv
module hz_flow_ctrl (
   input  logic load_use,
   input  logic br_taken,
   output logic hold,
   output logic bubble,
   output logic flush
);
   always_comb begin
      hold   = 1'b0;
      bubble = 1'b0;
      flush  = 1'b0;
      if (load_use) begin
         hold   = 1'b1;
         bubble = 1'b1;
      end else if (br_taken) begin
         flush  = 1'b1;
      end
   end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
   import hz_pkg::*;
#(
   parameter int AW = 5,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic [AW-1:0] ifid_src1,
   input  logic [AW-1:0] ifid_src2,
   input  logic [AW-1:0] idex_src1,
   input  logic [AW-1:0] idex_src2,
   input  logic [AW-1:0] idex_dst,
   input  logic          idex_mem_rd,
   input  logic [AW-1:0] exmem_dst,
   input  logic          exmem_reg_wr,
   input  logic [AW-1:0] memwb_dst,
   input  logic          memwb_reg_wr,
   input  logic          id_br_taken,
   output logic [1:0]    fwd_sel_a,
   output logic [1:0]    fwd_sel_b,
   output logic          pc_ifid_hold,
   output logic          idex_bubble,
   output logic          ifid_flush
);
   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("hz_unit: AW must lie in 1..8");
   end

   logic [NUM_OPERANDS-1:0][AW-1:0] op_src;
   fwd_sel_e                        op_sel [NUM_OPERANDS];
   logic                            lu_hit;

   assign op_src[0] = idex_src1;
   assign op_src[1] = idex_src2;

   for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_op
      hz_fwd_pick #(
         .AW(AW),
         .ZERO_REG_HARDWIRED(ZERO_REG_HARDWIRED)
      ) u_pick (
         .src    (op_src[g]),
         .mem_dst(exmem_dst),
         .mem_wr (exmem_reg_wr),
         .wb_dst (memwb_dst),
         .wb_wr  (memwb_reg_wr),
         .sel    (op_sel[g])
      );
   end

   assign fwd_sel_a = op_sel[0];
   assign fwd_sel_b = op_sel[1];

   hz_load_use #(.AW(AW)) u_lu (
      .id_src1  (ifid_src1),
      .id_src2  (ifid_src2),
      .ex_dst   (idex_dst),
      .ex_mem_rd(idex_mem_rd),
      .hit      (lu_hit)
   );

   hz_flow_ctrl u_flow (
      .load_use(lu_hit),
      .br_taken(id_br_taken),
      .hold    (pc_ifid_hold),
      .bubble  (idex_bubble),
      .flush   (ifid_flush)
   );
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
   parameter int AW = 5,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input logic [AW-1:0] ifid_src1,
   input logic [AW-1:0] ifid_src2,
   input logic [AW-1:0] idex_src1,
   input logic [AW-1:0] idex_src2,
   input logic [AW-1:0] idex_dst,
   input logic          idex_mem_rd,
   input logic [AW-1:0] exmem_dst,
   input logic          exmem_reg_wr,
   input logic [AW-1:0] memwb_dst,
   input logic          memwb_reg_wr,
   input logic          id_br_taken,
   input logic [1:0]    fwd_sel_a,
   input logic [1:0]    fwd_sel_b,
   input logic          pc_ifid_hold,
   input logic          idex_bubble,
   input logic          ifid_flush
);
   logic mem_ok;
   logic wb_ok;
   assign mem_ok = exmem_reg_wr && (!ZERO_REG_HARDWIRED || (exmem_dst != '0));
   assign wb_ok  = memwb_reg_wr && (!ZERO_REG_HARDWIRED || (memwb_dst != '0));

   always_comb begin
      // R12
      no_code3_chk: assert ((fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11))
         else $error("select code 3 produced");
      // R1
      a_mem_src_chk: assert ((fwd_sel_a != 2'b10) || (mem_ok && (exmem_dst == idex_src1)))
         else $error("operand A took EX/MEM without a live match");
      // R2
      a_wb_src_chk: assert ((fwd_sel_a != 2'b01) ||
                            (wb_ok && (memwb_dst == idex_src1) && !(mem_ok && (exmem_dst == idex_src1))))
         else $error("operand A took MEM/WB wrongly");
      // R6
      b_mem_src_chk: assert ((fwd_sel_b != 2'b10) || (mem_ok && (exmem_dst == idex_src2)))
         else $error("operand B took EX/MEM without a live match");
      // R7
      hold_cause_chk: assert (!pc_ifid_hold ||
                              (idex_mem_rd && ((idex_dst == ifid_src1) || (idex_dst == ifid_src2))))
         else $error("hold without a load-use dependency");
      // R9
      bubble_cause_chk: assert (!idex_bubble || idex_mem_rd)
         else $error("bubble without a load in ID/EX");
      // R10
      flush_cause_chk: assert (!ifid_flush || id_br_taken)
         else $error("flush without a taken branch");
      // R11
      hold_over_flush_chk: assert (!(pc_ifid_hold && ifid_flush))
         else $error("flush raised during a hold");
   end
endmodule

bind hz_unit hz_unit_chk #(
   .AW(AW),
   .ZERO_REG_HARDWIRED(ZERO_REG_HARDWIRED)
) u_chk (.*);

// File: tb/hz_unit_tb.sv
module hz_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] ifid_src1, ifid_src2, idex_src1, idex_src2, idex_dst;
   logic [4:0] exmem_dst, memwb_dst;
   logic       idex_mem_rd, exmem_reg_wr, memwb_reg_wr, id_br_taken;
   logic [1:0] fwd_sel_a, fwd_sel_b;
   logic       pc_ifid_hold, idex_bubble, ifid_flush;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hz_unit u_dut (
      .ifid_src1(ifid_src1), .ifid_src2(ifid_src2),
      .idex_src1(idex_src1), .idex_src2(idex_src2),
      .idex_dst(idex_dst), .idex_mem_rd(idex_mem_rd),
      .exmem_dst(exmem_dst), .exmem_reg_wr(exmem_reg_wr),
      .memwb_dst(memwb_dst), .memwb_reg_wr(memwb_reg_wr),
      .id_br_taken(id_br_taken),
      .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
      .pc_ifid_hold(pc_ifid_hold), .idex_bubble(idex_bubble),
      .ifid_flush(ifid_flush)
   );

   function automatic logic [1:0] m_fwd(logic [4:0] s, logic ew, logic [4:0] ed,
                                        logic mw, logic [4:0] md);
      if (ew && ed != 5'd0 && ed == s) return 2'b10;
      if (mw && md != 5'd0 && md == s) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic m_stall();
      return idex_mem_rd && (idex_dst == ifid_src1 || idex_dst == ifid_src2);
   endfunction

   task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      ifid_src1 = 0; ifid_src2 = 0; idex_src1 = 0; idex_src2 = 0; idex_dst = 0;
      exmem_dst = 0; memwb_dst = 0; idex_mem_rd = 0; exmem_reg_wr = 0;
      memwb_reg_wr = 0; id_br_taken = 0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #(CLK_PERIOD/4);
   endtask

   task automatic check_model(string tag);
      logic st;
      st = m_stall();
      chk({tag, " R1/R2/R3 fwd_a"}, fwd_sel_a,
          m_fwd(idex_src1, exmem_reg_wr, exmem_dst, memwb_reg_wr, memwb_dst));
      chk({tag, " R6 fwd_b"}, fwd_sel_b,
          m_fwd(idex_src2, exmem_reg_wr, exmem_dst, memwb_reg_wr, memwb_dst));
      chk({tag, " R7 hold"}, {1'b0, pc_ifid_hold}, {1'b0, st});
      chk({tag, " R9 bubble"}, {1'b0, idex_bubble}, {1'b0, st});
      chk({tag, " R10/R11 flush"}, {1'b0, ifid_flush}, {1'b0, id_br_taken && !st});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      clear_all();
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // R12: all-zero inputs give all-zero outputs
      step(); clear_all(); settle();
      chk("R12 zero fwd_a", fwd_sel_a, 2'b00);
      chk("R12 zero fwd_b", fwd_sel_b, 2'b00);
      chk("R12 zero ctrl", {pc_ifid_hold, ifid_flush}, 2'b00);

      // R1
      step(); clear_all(); exmem_reg_wr = 1; exmem_dst = 3; idex_src1 = 3; settle();
      chk("R1 exmem match", fwd_sel_a, 2'b10);

      // R2
      step(); clear_all(); memwb_reg_wr = 1; memwb_dst = 4; idex_src1 = 4;
      exmem_reg_wr = 1; exmem_dst = 5; settle();
      chk("R2 memwb match", fwd_sel_a, 2'b01);

      // R3
      step(); clear_all(); exmem_reg_wr = 1; memwb_reg_wr = 1;
      exmem_dst = 6; memwb_dst = 6; idex_src1 = 6; idex_src2 = 6; settle();
      chk("R3 priority a", fwd_sel_a, 2'b10);
      chk("R3 priority b", fwd_sel_b, 2'b10);

      // R4
      step(); clear_all(); exmem_dst = 7; memwb_dst = 7; idex_src1 = 7; idex_src2 = 7; settle();
      chk("R4 no write flag a", fwd_sel_a, 2'b00);
      chk("R4 no write flag b", fwd_sel_b, 2'b00);

      // R5
      step(); clear_all(); exmem_reg_wr = 1; memwb_reg_wr = 1; settle();
      chk("R5 reg zero a", fwd_sel_a, 2'b00);
      chk("R5 reg zero b", fwd_sel_b, 2'b00);

      // R6
      step(); clear_all(); exmem_reg_wr = 1; exmem_dst = 8; idex_src1 = 8;
      memwb_reg_wr = 1; memwb_dst = 9; idex_src2 = 9; settle();
      chk("R6 a from exmem", fwd_sel_a, 2'b10);
      chk("R6 b from memwb", fwd_sel_b, 2'b01);

      // R7 / R9: load dest matches second decode source
      step(); clear_all(); idex_mem_rd = 1; idex_dst = 9; ifid_src1 = 2; ifid_src2 = 9; settle();
      chk("R7 hold on src2", {1'b0, pc_ifid_hold}, 2'b01);
      chk("R9 bubble on stall", {1'b0, idex_bubble}, 2'b01);

      step(); clear_all(); idex_mem_rd = 1; idex_dst = 10; ifid_src1 = 10; settle();
      chk("R7 hold on src1", {1'b0, pc_ifid_hold}, 2'b01);

      // R8
      step(); clear_all(); idex_dst = 11; ifid_src1 = 11; ifid_src2 = 11; settle();
      chk("R8 non-load no hold", {pc_ifid_hold, idex_bubble}, 2'b00);
      step(); clear_all(); idex_mem_rd = 1; idex_dst = 12; ifid_src1 = 13; ifid_src2 = 14; settle();
      chk("R8 no match no hold", {pc_ifid_hold, idex_bubble}, 2'b00);

      // R10
      step(); clear_all(); id_br_taken = 1; idex_dst = 1; ifid_src1 = 2; ifid_src2 = 3; settle();
      chk("R10 taken flush", {1'b0, ifid_flush}, 2'b01);
      step(); id_br_taken = 0; settle();
      chk("R10 not taken", {1'b0, ifid_flush}, 2'b00);

      // R11
      step(); clear_all(); id_br_taken = 1; idex_mem_rd = 1; idex_dst = 5; ifid_src1 = 5; settle();
      chk("R11 hold wins", {pc_ifid_hold, ifid_flush}, 2'b10);

      // R12 and all others: random vectors over a narrow register range
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3000; i++) begin
         step();
         ifid_src1    = 5'($urandom_range(0, 3));
         ifid_src2    = 5'($urandom_range(0, 3));
         idex_src1    = 5'($urandom_range(0, 3));
         idex_src2    = 5'($urandom_range(0, 3));
         idex_dst     = 5'($urandom_range(0, 3));
         exmem_dst    = 5'($urandom_range(0, 3));
         memwb_dst    = 5'($urandom_range(0, 3));
         idex_mem_rd  = 1'($urandom_range(0, 1));
         exmem_reg_wr = 1'($urandom_range(0, 1));
         memwb_reg_wr = 1'($urandom_range(0, 1));
         id_br_taken  = 1'($urandom_range(0, 1));
         settle();
         check_model("R12 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule